// File: doc/BRIEF.md
# Dual-Path Conversion Result Holding Buffer

This block sits between two conversion result producers, a down-sampler path and a decimation-filter path, and whatever reads their results, such as software or a DMA engine. Each path has a one-word holding register with a valid flag, a sticky overrun flag and a DMA request line. A result strobe loads the word into the holding register. A read acknowledge frees the register again.

Each result carries a tag that says which input arrangement produced it. Words from a single negative-ended input, and words from a differential input, can each be stored as their bitwise one's complement. A separate enable selects this for each of the two input types. Words from a single positive-ended input are always stored unchanged. Each path also has its own overrun policy. When a new word arrives while the held word has not yet been read, the policy either keeps the old word or replaces it with the new one.

Top module: `adc_result_buffer`

## Requirements
- R1: After reset, every held word is zero and every valid, overrun and DMA request output is 0.
- R2: A strobe on a path whose valid flag is clear stores the adjusted word: the data and valid=1 appear on the outputs after the next rising clock edge.
- R3: With cfg_inv_neg=1, a word tagged 1 (single negative input) is stored as its bitwise one's complement. With cfg_inv_neg=0 it is stored unchanged.
- R4: With cfg_inv_diff=1, a word tagged 2 (differential input) is stored as its one's complement. Words tagged 0 (single positive input) or 3 (unused) are never inverted, whatever the enables are.
- R5: With the path's replace bit at 0, a strobe that arrives while valid=1 and without an acknowledge leaves the held word unchanged and drops the new one.
- R6: With the path's replace bit at 1, such a strobe replaces the held word with the new adjusted word, and valid stays 1.
- R7: A strobe while valid=1 and without an acknowledge sets the path's overrun flag. The flag stays set until the path's overrun clear input is asserted. If a clear and a new overrun happen in the same cycle, the flag ends up set.
- R8: An acknowledge without a strobe clears valid and the DMA request on the next edge. An acknowledge together with a strobe stores the new word with valid=1 and does not set overrun.
- R9: Every store loads the path's DMA request with that path's DMA enable value. A dropped word (R5) leaves the request unchanged.
- R10: The two paths are independent. Stimulus on one path never changes the outputs of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_inv_neg | input | 1 | Invert words from a single negative input |
| cfg_inv_diff | input | 1 | Invert words from a differential input |
| ds_replace | input | 1 | Down-sampler overrun policy: 1 replaces, 0 keeps |
| ds_dma_en | input | 1 | Down-sampler DMA enable |
| ds_stb | input | 1 | Down-sampler result strobe |
| ds_data | input | DATA_W | Down-sampler result word |
| ds_kind | input | 2 | Input tag: 0 positive, 1 negative, 2 differential, 3 unused |
| ds_ack | input | 1 | Down-sampler read acknowledge |
| ds_ovr_clr | input | 1 | Down-sampler overrun clear |
| ds_q | output | DATA_W | Down-sampler held word |
| ds_valid | output | 1 | Down-sampler held word valid |
| ds_ovr | output | 1 | Down-sampler sticky overrun |
| ds_dma_req | output | 1 | Down-sampler DMA request |
| df_replace | input | 1 | Decimation path overrun policy |
| df_dma_en | input | 1 | Decimation path DMA enable |
| df_stb | input | 1 | Decimation path result strobe |
| df_data | input | DATA_W | Decimation path result word |
| df_kind | input | 2 | Decimation path input tag, same coding as ds_kind |
| df_ack | input | 1 | Decimation path read acknowledge |
| df_ovr_clr | input | 1 | Decimation path overrun clear |
| df_q | output | DATA_W | Decimation path held word |
| df_valid | output | 1 | Decimation path held word valid |
| df_ovr | output | 1 | Decimation path sticky overrun |
| df_dma_req | output | 1 | Decimation path DMA request |

## Verification
The hardest cases to reach are the three-way collisions, where a strobe, an acknowledge and an overrun clear all land on a path in the same cycle while the word is held, under both policies. Random stimulus alone reaches these only rarely. Directed sequences first fill a path and then raise all three inputs together. After that, a long random phase drives both paths at once with high strobe and acknowledge rates, so that the paths collide with each other and with themselves often.

// File: rtl/adcbuf_pkg.sv
package adcbuf_pkg;
   typedef enum logic [1:0] {
      KIND_POS  = 2'd0,
      KIND_NEG  = 2'd1,
      KIND_DIFF = 2'd2,
      KIND_RSVD = 2'd3
   } in_kind_e;

   localparam int unsigned NPATH = 2;
   localparam int unsigned PATH_DS = 0;
   localparam int unsigned PATH_DF = 1;
endpackage

// File: rtl/adcbuf_polarity.sv
module adcbuf_polarity
   import adcbuf_pkg::*;
#(
   parameter int unsigned DATA_W = 12
) (
   input  logic [DATA_W-1:0] raw,
   input  logic [1:0]        kind,
   input  logic              inv_neg,
   input  logic              inv_diff,
   output logic [DATA_W-1:0] adj
);
   logic flip;

   always_comb begin
      unique case (in_kind_e'(kind))
         KIND_NEG:  flip = inv_neg;
         KIND_DIFF: flip = inv_diff;
         default:   flip = 1'b0;
      endcase
      adj = flip ? ~raw : raw;
   end
endmodule

// File: rtl/adcbuf_slot.sv
module adcbuf_slot #(
   parameter int unsigned DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              replace,
   input  logic              dma_en,
   input  logic              stb,
   input  logic [DATA_W-1:0] word,
   input  logic              ack,
   input  logic              ovr_clr,
   output logic [DATA_W-1:0] q,
   output logic              valid,
   output logic              ovr,
   output logic              dma_req
);
   logic do_store;
   logic collide;

   assign collide  = stb & valid & ~ack;
   assign do_store = stb & (~valid | ack | replace);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q       <= '0;
         valid   <= 1'b0;
         ovr     <= 1'b0;
         dma_req <= 1'b0;
      end else begin
         if (do_store) begin
            q       <= word;
            valid   <= 1'b1;
            dma_req <= dma_en;
         end else if (ack) begin
            valid   <= 1'b0;
            dma_req <= 1'b0;
         end
         if (collide)
            ovr <= 1'b1;
         else if (ovr_clr)
            ovr <= 1'b0;
      end
   end
endmodule

// File: rtl/adc_result_buffer.sv
module adc_result_buffer
   import adcbuf_pkg::*;
#(
   parameter int unsigned DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_inv_neg,
   input  logic              cfg_inv_diff,
   input  logic              ds_replace,
   input  logic              ds_dma_en,
   input  logic              ds_stb,
   input  logic [DATA_W-1:0] ds_data,
   input  logic [1:0]        ds_kind,
   input  logic              ds_ack,
   input  logic              ds_ovr_clr,
   output logic [DATA_W-1:0] ds_q,
   output logic              ds_valid,
   output logic              ds_ovr,
   output logic              ds_dma_req,
   input  logic              df_replace,
   input  logic              df_dma_en,
   input  logic              df_stb,
   input  logic [DATA_W-1:0] df_data,
   input  logic [1:0]        df_kind,
   input  logic              df_ack,
   input  logic              df_ovr_clr,
   output logic [DATA_W-1:0] df_q,
   output logic              df_valid,
   output logic              df_ovr,
   output logic              df_dma_req
);
   generate
      if (DATA_W < 2 || DATA_W > 32) begin : g_bad_width
         $error("adc_result_buffer: DATA_W must lie in 2..32");
      end
   endgenerate

   logic [NPATH-1:0]             p_replace, p_dma_en, p_stb, p_ack, p_clr;
   logic [NPATH-1:0][DATA_W-1:0] p_data, p_adj, p_q;
   logic [NPATH-1:0][1:0]        p_kind;
   logic [NPATH-1:0]             p_valid, p_ovr, p_dma;

   assign p_replace = {df_replace, ds_replace};
   assign p_dma_en  = {df_dma_en,  ds_dma_en};
   assign p_stb     = {df_stb,     ds_stb};
   assign p_ack     = {df_ack,     ds_ack};
   assign p_clr     = {df_ovr_clr, ds_ovr_clr};
   assign p_data    = {df_data,    ds_data};
   assign p_kind    = {df_kind,    ds_kind};

   for (genvar p = 0; p < NPATH; p++) begin : g_path
      adcbuf_polarity #(.DATA_W(DATA_W)) u_pol (
         .raw      (p_data[p]),
         .kind     (p_kind[p]),
         .inv_neg  (cfg_inv_neg),
         .inv_diff (cfg_inv_diff),
         .adj      (p_adj[p])
      );
      adcbuf_slot #(.DATA_W(DATA_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .replace  (p_replace[p]),
         .dma_en   (p_dma_en[p]),
         .stb      (p_stb[p]),
         .word     (p_adj[p]),
         .ack      (p_ack[p]),
         .ovr_clr  (p_clr[p]),
         .q        (p_q[p]),
         .valid    (p_valid[p]),
         .ovr      (p_ovr[p]),
         .dma_req  (p_dma[p])
      );
   end

   assign ds_q       = p_q[PATH_DS];
   assign ds_valid   = p_valid[PATH_DS];
   assign ds_ovr     = p_ovr[PATH_DS];
   assign ds_dma_req = p_dma[PATH_DS];
   assign df_q       = p_q[PATH_DF];
   assign df_valid   = p_valid[PATH_DF];
   assign df_ovr     = p_ovr[PATH_DF];
   assign df_dma_req = p_dma[PATH_DF];
endmodule

// File: rtl/adcbuf_checker.sv
module adcbuf_checker #(
   parameter int unsigned DATA_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ds_replace,
   input logic              ds_stb,
   input logic              ds_ack,
   input logic              ds_ovr_clr,
   input logic [DATA_W-1:0] ds_q,
   input logic              ds_valid,
   input logic              ds_ovr,
   input logic              ds_dma_req,
   input logic              df_replace,
   input logic              df_stb,
   input logic              df_ack,
   input logic              df_ovr_clr,
   input logic [DATA_W-1:0] df_q,
   input logic              df_valid,
   input logic              df_ovr,
   input logic              df_dma_req
);
   logic [1:0] rep, stb, ack, clr, vld, ovr, dma;
   logic [1:0][DATA_W-1:0] q;
   assign rep = {df_replace, ds_replace};
   assign stb = {df_stb, ds_stb};
   assign ack = {df_ack, ds_ack};
   assign clr = {df_ovr_clr, ds_ovr_clr};
   assign vld = {df_valid, ds_valid};
   assign ovr = {df_ovr, ds_ovr};
   assign dma = {df_dma_req, ds_dma_req};
   assign q   = {df_q, ds_q};

   for (genvar p = 0; p < 2; p++) begin : g_chk
      a_r2_store_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
         stb[p] |=> vld[p]);
      a_r5_keep_holds_word: assert property (@(posedge clk) disable iff (!rst_n)
         (stb[p] && vld[p] && !ack[p] && !rep[p]) |=> $stable(q[p]));
      a_r7_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
         (stb[p] && vld[p] && !ack[p]) |=> ovr[p]);
      a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (ovr[p] && !clr[p]) |=> ovr[p]);
      a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (ack[p] && !stb[p]) |=> (!vld[p] && !dma[p]));
      a_r8_ack_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
         (ack[p] && !ovr[p]) |=> !ovr[p]);
      a_r9_dma_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
         dma[p] |-> vld[p]);
   end
endmodule

bind adc_result_buffer adcbuf_checker #(.DATA_W(DATA_W)) u_adcbuf_checker (
   .clk(clk), .rst_n(rst_n),
   .ds_replace(ds_replace), .ds_stb(ds_stb), .ds_ack(ds_ack), .ds_ovr_clr(ds_ovr_clr),
   .ds_q(ds_q), .ds_valid(ds_valid), .ds_ovr(ds_ovr), .ds_dma_req(ds_dma_req),
   .df_replace(df_replace), .df_stb(df_stb), .df_ack(df_ack), .df_ovr_clr(df_ovr_clr),
   .df_q(df_q), .df_valid(df_valid), .df_ovr(df_ovr), .df_dma_req(df_dma_req)
);

// File: tb/adc_result_buffer_bench.sv
module adc_result_buffer_bench;
   localparam int W = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic inv_neg = 0, inv_diff = 0;
   logic [1:0] rep = 0, den = 0, stb = 0, ack = 0, clr = 0;
   logic [1:0][W-1:0] dat = '0;
   logic [1:0][1:0] kind = '0;

   logic [W-1:0] ds_q, df_q;
   logic ds_valid, ds_ovr, ds_dma_req, df_valid, df_ovr, df_dma_req;

   adc_result_buffer #(.DATA_W(W)) u_adc_result_buffer (
      .clk(clk), .rst_n(rst_n), .cfg_inv_neg(inv_neg), .cfg_inv_diff(inv_diff),
      .ds_replace(rep[0]), .ds_dma_en(den[0]), .ds_stb(stb[0]), .ds_data(dat[0]),
      .ds_kind(kind[0]), .ds_ack(ack[0]), .ds_ovr_clr(clr[0]),
      .ds_q(ds_q), .ds_valid(ds_valid), .ds_ovr(ds_ovr), .ds_dma_req(ds_dma_req),
      .df_replace(rep[1]), .df_dma_en(den[1]), .df_stb(stb[1]), .df_data(dat[1]),
      .df_kind(kind[1]), .df_ack(ack[1]), .df_ovr_clr(clr[1]),
      .df_q(df_q), .df_valid(df_valid), .df_ovr(df_ovr), .df_dma_req(df_dma_req)
   );

   int checks = 0, fails = 0;
   logic [1:0][W-1:0] m_q = '0;
   logic [1:0] m_v = 0, m_o = 0, m_d = 0;

   function automatic logic [W-1:0] adjust(logic [W-1:0] d, logic [1:0] k, logic sn, logic df);
      if (k == 2'd1 && sn) return ~d;
      if (k == 2'd2 && df) return ~d;
      return d;
   endfunction

   function automatic logic [W-1:0] out_q(int p);
      return (p == 0) ? ds_q : df_q;
   endfunction
   function automatic logic [2:0] out_f(int p);
      return (p == 0) ? {ds_valid, ds_ovr, ds_dma_req} : {df_valid, df_ovr, df_dma_req};
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      for (int p = 0; p < 2; p++) begin
         chk($sformatf("R2 data path%0d", p), 32'(out_q(p)), 32'(m_q[p]));
         chk($sformatf("R8 valid path%0d", p), 32'(out_f(p)[2]), 32'(m_v[p]));
         chk($sformatf("R7 overrun path%0d", p), 32'(out_f(p)[1]), 32'(m_o[p]));
         chk($sformatf("R9 dma path%0d", p), 32'(out_f(p)[0]), 32'(m_d[p]));
      end
   endtask

   // one clock: model next state from current inputs, then compare after the edge
   task automatic step();
      logic [1:0][W-1:0] nq;
      logic [1:0] nv, no, nd;
      for (int p = 0; p < 2; p++) begin
         logic st, ov;
         st = stb[p] && (!m_v[p] || ack[p] || rep[p]);
         ov = stb[p] && m_v[p] && !ack[p];
         nq[p] = st ? adjust(dat[p], kind[p], inv_neg, inv_diff) : m_q[p];
         nv[p] = st ? 1'b1 : (ack[p] ? 1'b0 : m_v[p]);
         nd[p] = st ? den[p] : (ack[p] ? 1'b0 : m_d[p]);
         no[p] = ov ? 1'b1 : (clr[p] ? 1'b0 : m_o[p]);
      end
      @(posedge clk);
      #1;
      m_q = nq; m_v = nv; m_o = no; m_d = nd;
      compare_all();
      stb = 0; ack = 0; clr = 0;
   endtask

   task automatic put(int p, logic [W-1:0] d, logic [1:0] k);
      stb[p] = 1'b1; dat[p] = d; kind[p] = k;
   endtask

   initial begin
      #4_000_000;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int unsigned seed = 32'h5eed_1234;
      void'($urandom(seed));
      repeat (2) @(posedge clk);
      #1;
      compare_all();                                      // R1 reset state
      chk("R1 reset ds_q", 32'(ds_q), 0);
      rst_n = 1'b1;
      #20;

      // R4: positive never inverted even with both enables
      inv_neg = 1; inv_diff = 1;
      put(0, 12'h0F3, 2'd0); step();
      chk("R4 positive not inverted", 32'(ds_q), 32'h0F3);
      chk("R10 df untouched", 32'(df_valid), 0);

      // R5 keep policy + R7 overrun
      rep[0] = 0; put(0, 12'h111, 2'd0); step();
      chk("R5 keep old word", 32'(ds_q), 32'h0F3);
      chk("R7 overrun set", 32'(ds_ovr), 1);
      step();
      chk("R7 overrun sticky", 32'(ds_ovr), 1);
      // R7 clear and new overrun same cycle: set wins
      clr[0] = 1; put(0, 12'h222, 2'd0); step();
      chk("R7 set beats clear", 32'(ds_ovr), 1);
      clr[0] = 1; step();
      chk("R7 clear", 32'(ds_ovr), 0);

      // R6 replace policy
      rep[0] = 1; put(0, 12'h3C5, 2'd0); step();
      chk("R6 replaced", 32'(ds_q), 32'h3C5);

      // R8 ack + strobe together: stored, no overrun
      ack[0] = 1; put(0, 12'h456, 2'd0); rep[0] = 0; step();
      chk("R8 ack+stb stores", 32'(ds_q), 32'h456);
      ack[0] = 1; step();
      chk("R8 ack clears valid", 32'(ds_valid), 0);

      // R3 negative inversion on df path, with DMA (R9)
      den[1] = 1; put(1, 12'h0A5, 2'd1); step();
      chk("R3 negative inverted", 32'(df_q), 32'hF5A);
      chk("R9 dma raised", 32'(df_dma_req), 1);
      ack[1] = 1; step();
      inv_neg = 0; put(1, 12'h0A5, 2'd1); step();
      chk("R3 negative not inverted", 32'(df_q), 32'h0A5);
      ack[1] = 1; step();
      put(1, 12'h801, 2'd2); step();
      chk("R4 differential inverted", 32'(df_q), 32'h7FE);
      ack[1] = 1; step();
      put(1, 12'h801, 2'd3); step();
      chk("R4 unused tag not inverted", 32'(df_q), 32'h801);
      chk("R10 ds idle unchanged", 32'(ds_q), 32'h456);

      // all three events together on a full df path, keep policy
      rep[1] = 0; ack[1] = 1; clr[1] = 1; put(1, 12'h777, 2'd0); step();

      // random phase
      for (int i = 0; i < 3000; i++) begin
         for (int p = 0; p < 2; p++) begin
            stb[p]  = ($urandom % 3) != 0;
            ack[p]  = ($urandom % 3) == 0;
            clr[p]  = ($urandom % 5) == 0;
            dat[p]  = W'($urandom);
            kind[p] = 2'($urandom);
            if ($urandom % 16 == 0) rep[p] = ~rep[p];
            if ($urandom % 16 == 0) den[p] = ~den[p];
         end
         if ($urandom % 32 == 0) inv_neg = ~inv_neg;
         if ($urandom % 32 == 0) inv_diff = ~inv_diff;
         step();
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule